// File: doc/BRIEF.md
# Multicast Packet-to-Flit Injector

This block is the injection side of one virtual channel in a tile's network adapter. A requester hands it whole packets, each carrying a body, a flag saying whether the body holds data, a list of destination tiles and a mask of which list entries are live. Packets wait in a small queue. The packet at the head of the queue is cut into fixed-width flits and sent to the router's local port once for every live destination, because the network itself routes unicast only.

Live destinations are visited in round-robin order over the mask, and a served-destination mask records who has already received a copy. The queue head leaves only after the last copy's final flit has gone out. Each flit carries its kind (opening, middle, closing, or a single flit that opens and closes), its payload chunk, the destination tile and the first hop chosen by X-then-Y dimension-order routing from this tile's own position. A stop input from the router freezes injection. A pending output tells an external port arbiter that this channel has traffic. An almost-full output tells the requester to hold off.

A build-time switch selects how destinations are named. In list mode each mask bit picks an address from the destination array. In one-hot mode the mask is indexed by tile number, and the granted bit index is itself the tile address.

Top module: `pkt_flit_injector`

## Requirements
- R1: A packet is written into the queue on a clock edge where `pkt_valid` is high and the queue is not full. Packets leave in the order they arrived, and each stored entry keeps its body, has-data flag, destination array and destination mask.
- R2: `pkt_stop` is high exactly when the number of stored packets is at least `STOP_LEVEL` (default `QDEPTH-1`). An empty queue never raises it.
- R3: `vc_pending` is high exactly when the queue holds at least one packet. No flit is sent while it is low.
- R4: For each packet, one unicast copy is sent to every destination whose mask bit is set, and no copy is sent to any other destination. The next destination is the first set and still-unserved mask bit found by searching upward, cyclically, from the index after the most recently served one. This search position carries over from one packet to the next and starts at index 0 after reset.
- R5: In list mode (`ONEHOT_DEST=0`), destination i is `pkt_dest[i*ADDR_W +: ADDR_W]`. In one-hot mode the granted index is the address. In both modes X is the low `X_W` bits of the address and Y is the `Y_W` bits above them. `flit_dest` stays constant across all flits of one copy.
- R6: While `router_stop` is high, `flit_valid` is low and the position within the packet is held. The flit stream resumes with the flit that was due, and none is lost or repeated.
- R7: `flit_kind` uses 0 = opening, 1 = middle, 2 = closing, 3 = single. A copy of a data packet is `FLITS` flits: opening, then middles, then closing. Flit k carries `pkt_body[k*CHUNK_W +: CHUNK_W]`.
- R8: A packet whose has-data flag is 0 is sent as one single-kind flit per destination, and that flit carries chunk 0 of the body.
- R9: The queue head is removed on the edge that ends the last copy's final flit, so the next packet's first flit can follow in the very next cycle. A packet with an all-zero mask is removed one cycle after it becomes the head and sends no flit.
- R10: `flit_dir` gives the first hop: 1 (east) if dest X > `MY_X`, 2 (west) if dest X < `MY_X`, otherwise 3 (north) if dest Y > `MY_Y`, 4 (south) if dest Y < `MY_Y`, and 0 (local) if both are equal.
- R11: After a synchronous active-high reset, `flit_valid`, `vc_pending` and `pkt_stop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Requester offers a packet this cycle |
| pkt_body | input | FLITS*CHUNK_W | Packet body, chunk 0 in the low bits |
| pkt_has_data | input | 1 | 1: full-length packet; 0: single-flit packet |
| pkt_dest | input | NUM_DEST*X_W+Y_W sum per entry (NUM_DEST*ADDR_W) | Destination tile addresses, entry i at i*ADDR_W |
| pkt_dest_mask | input | NUM_DEST | Live destinations of the packet |
| pkt_stop | output | 1 | Queue almost full; requester must hold off |
| vc_pending | output | 1 | Queue non-empty; request to the port arbiter |
| router_stop | input | 1 | Router back-pressure; no flit may be sent |
| flit_valid | output | 1 | A flit is presented this cycle |
| flit_kind | output | 2 | Flit kind code |
| flit_payload | output | CHUNK_W | Body chunk carried by the flit |
| flit_dest | output | X_W+Y_W | Destination tile, X in the low bits |
| flit_dir | output | 3 | First-hop direction code |

## Verification
A corrupted served mask or a corrupted search position shows up at the ports within one copy. A copy goes to the wrong tile, is repeated, or is skipped, and the next copy comes out in the wrong order. The reference model catches this on the first flit of the affected copy. A flit counter that drifts under back-pressure shows up on the next flit as a wrong payload chunk or a wrong kind. The bench mixes random stalls with random multicast masks so that stalls land inside packets and at copy boundaries. A wrong dequeue shows as a skipped or repeated packet in the stream, and within a cycle as a mismatch of `vc_pending` or `pkt_stop` against the modelled occupancy.

// File: rtl/inj_pkg.sv
package inj_pkg;

    // Flit kind codes; a neighbour decodes these, so the values are fixed.
    typedef enum logic [1:0] {
        FK_OPEN   = 2'd0,
        FK_MIDDLE = 2'd1,
        FK_CLOSE  = 2'd2,
        FK_SINGLE = 2'd3
    } flit_kind_e;

    // First-hop direction codes.
    typedef enum logic [2:0] {
        HOP_LOCAL = 3'd0,
        HOP_EAST  = 3'd1,
        HOP_WEST  = 3'd2,
        HOP_NORTH = 3'd3,
        HOP_SOUTH = 3'd4
    } hop_dir_e;

    // X first, then Y.
    function automatic hop_dir_e xy_next_hop(input int unsigned tx, input int unsigned ty,
                                             input int unsigned hx, input int unsigned hy);
        if (tx > hx)      return HOP_EAST;
        else if (tx < hx) return HOP_WEST;
        else if (ty > hy) return HOP_NORTH;
        else if (ty < hy) return HOP_SOUTH;
        else              return HOP_LOCAL;
    endfunction

    // Kind of flit number idx in a copy of total flits.
    function automatic flit_kind_e flit_kind_of(input int unsigned idx, input int unsigned total);
        if (total <= 1)            return FK_SINGLE;
        else if (idx == 0)         return FK_OPEN;
        else if (idx == total - 1) return FK_CLOSE;
        else                       return FK_MIDDLE;
    endfunction

endpackage

// File: rtl/inj_queue.sv
module inj_queue #(
    parameter int WIDTH    = 8,
    parameter int DEPTH    = 4,
    parameter int AF_LEVEL = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             almost_full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] fill;
    logic             full, do_wr, do_rd;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (32'(p) == DEPTH - 1) return '0;
        else                     return p + 1'b1;
    endfunction

    assign full        = (fill == CNT_W'(DEPTH));
    assign empty       = (fill == '0);
    assign almost_full = (fill >= CNT_W'(AF_LEVEL));
    assign do_wr       = wr_en & ~full;
    assign do_rd       = rd_en & ~empty;
    assign rd_data     = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) slots[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/inj_rr_pick.sv
module inj_rr_pick #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    input  logic             advance,
    output logic [N-1:0]     grant_oh,
    output logic [IDX_W-1:0] grant_idx,
    output logic             any
);
    logic [IDX_W-1:0] last_idx;
    logic             found;

    assign any = |req;

    // Search upward, cyclically, from the slot after the last one served.
    always_comb begin
        grant_idx = '0;
        grant_oh  = '0;
        found     = 1'b0;
        for (int o = 1; o <= N; o++) begin
            if (!found && req[(int'(last_idx) + o) % N]) begin
                found     = 1'b1;
                grant_idx = IDX_W'((int'(last_idx) + o) % N);
            end
        end
        if (found) grant_oh[grant_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                  last_idx <= IDX_W'(N - 1);
        else if (advance && found) last_idx <= grant_idx;
    end
endmodule

// File: rtl/inj_serializer.sv
module inj_serializer
    import inj_pkg::*;
#(
    parameter int NUM_DEST    = 4,
    parameter int FLITS       = 4,
    parameter int CHUNK_W     = 16,
    parameter int X_W         = 2,
    parameter int Y_W         = 2,
    parameter int ONEHOT_DEST = 0,
    parameter int MY_X        = 1,
    parameter int MY_Y        = 2,
    localparam int BODY_W = FLITS * CHUNK_W,
    localparam int ADDR_W = X_W + Y_W,
    localparam int DEST_W = NUM_DEST * ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                head_valid,
    input  logic [BODY_W-1:0]   head_body,
    input  logic                head_has_data,
    input  logic [DEST_W-1:0]   head_dest,
    input  logic [NUM_DEST-1:0] head_mask,
    input  logic                router_stop,
    output logic                flit_valid,
    output flit_kind_e          flit_kind,
    output logic [CHUNK_W-1:0]  flit_payload,
    output logic [ADDR_W-1:0]   flit_dest,
    output hop_dir_e            flit_dir,
    output logic                pop
);
    localparam int CNT_W = (FLITS > 1) ? $clog2(FLITS) : 1;
    localparam int IDX_W = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1;

    logic [NUM_DEST-1:0] served;
    logic [NUM_DEST-1:0] remaining;
    logic [NUM_DEST-1:0] grant_oh;
    logic [IDX_W-1:0]    grant_idx;
    logic                any_left;
    logic [CNT_W-1:0]    flit_cnt;
    int unsigned         copy_len;
    logic                last_flit;
    logic                send;
    logic                copy_done;
    logic [ADDR_W-1:0]   tile_addr;
    logic [X_W-1:0]      tile_x;
    logic [Y_W-1:0]      tile_y;

    assign remaining = head_mask & ~served;

    inj_rr_pick #(.N(NUM_DEST)) u_dest_pick (
        .clk       (clk),
        .rst       (rst),
        .req       (remaining),
        .advance   (copy_done),
        .grant_oh  (grant_oh),
        .grant_idx (grant_idx),
        .any       (any_left)
    );

    // Destination address: from the array, or the granted index itself.
    generate
        if (ONEHOT_DEST != 0) begin : g_onehot_addr
            assign tile_addr = ADDR_W'(grant_idx);
        end else begin : g_list_addr
            assign tile_addr = head_dest[32'(grant_idx) * ADDR_W +: ADDR_W];
        end
    endgenerate

    assign tile_x = tile_addr[X_W-1:0];
    assign tile_y = tile_addr[ADDR_W-1:X_W];

    assign copy_len  = head_has_data ? FLITS : 1;
    assign last_flit = (32'(flit_cnt) == copy_len - 1);
    assign send      = head_valid & any_left & ~router_stop;
    assign copy_done = send & last_flit;

    // Dequeue with the final flit of the final copy, or at once if nothing is live.
    assign pop = head_valid & (~any_left | (copy_done & ((remaining & ~grant_oh) == '0)));

    always_comb begin
        flit_valid   = send;
        flit_kind    = flit_kind_of(32'(flit_cnt), copy_len);
        flit_payload = head_body[32'(flit_cnt) * CHUNK_W +: CHUNK_W];
        flit_dest    = tile_addr;
        flit_dir     = xy_next_hop(32'(tile_x), 32'(tile_y), MY_X, MY_Y);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flit_cnt <= '0;
            served   <= '0;
        end else begin
            if (send) flit_cnt <= last_flit ? '0 : flit_cnt + 1'b1;
            if (pop)            served <= '0;
            else if (copy_done) served <= served | grant_oh;
        end
    end
endmodule

// File: rtl/pkt_flit_injector.sv
module pkt_flit_injector
    import inj_pkg::*;
#(
    parameter int NUM_DEST    = 4,
    parameter int FLITS       = 4,
    parameter int CHUNK_W     = 16,
    parameter int X_W         = 2,
    parameter int Y_W         = 2,
    parameter int QDEPTH      = 4,
    parameter int STOP_LEVEL  = QDEPTH - 1,
    parameter int ONEHOT_DEST = 0,
    parameter int MY_X        = 1,
    parameter int MY_Y        = 2,
    localparam int BODY_W = FLITS * CHUNK_W,
    localparam int ADDR_W = X_W + Y_W,
    localparam int DEST_W = NUM_DEST * ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pkt_valid,
    input  logic [BODY_W-1:0]   pkt_body,
    input  logic                pkt_has_data,
    input  logic [DEST_W-1:0]   pkt_dest,
    input  logic [NUM_DEST-1:0] pkt_dest_mask,
    output logic                pkt_stop,
    output logic                vc_pending,
    input  logic                router_stop,
    output logic                flit_valid,
    output logic [1:0]          flit_kind,
    output logic [CHUNK_W-1:0]  flit_payload,
    output logic [ADDR_W-1:0]   flit_dest,
    output logic [2:0]          flit_dir
);
    typedef struct packed {
        logic [BODY_W-1:0]   body;
        logic                has_data;
        logic [DEST_W-1:0]   dests;
        logic [NUM_DEST-1:0] mask;
    } q_entry_t;

    q_entry_t   in_ent, head_ent;
    logic       q_empty, q_pop;
    flit_kind_e kind_e;
    hop_dir_e   dir_e;

    assign in_ent = '{body: pkt_body, has_data: pkt_has_data, dests: pkt_dest, mask: pkt_dest_mask};

    inj_queue #(
        .WIDTH    ($bits(q_entry_t)),
        .DEPTH    (QDEPTH),
        .AF_LEVEL (STOP_LEVEL)
    ) u_queue (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (pkt_valid),
        .wr_data     (in_ent),
        .rd_en       (q_pop),
        .rd_data     (head_ent),
        .empty       (q_empty),
        .almost_full (pkt_stop)
    );

    assign vc_pending = ~q_empty;

    inj_serializer #(
        .NUM_DEST    (NUM_DEST),
        .FLITS       (FLITS),
        .CHUNK_W     (CHUNK_W),
        .X_W         (X_W),
        .Y_W         (Y_W),
        .ONEHOT_DEST (ONEHOT_DEST),
        .MY_X        (MY_X),
        .MY_Y        (MY_Y)
    ) u_ser (
        .clk           (clk),
        .rst           (rst),
        .head_valid    (~q_empty),
        .head_body     (head_ent.body),
        .head_has_data (head_ent.has_data),
        .head_dest     (head_ent.dests),
        .head_mask     (head_ent.mask),
        .router_stop   (router_stop),
        .flit_valid    (flit_valid),
        .flit_kind     (kind_e),
        .flit_payload  (flit_payload),
        .flit_dest     (flit_dest),
        .flit_dir      (dir_e),
        .pop           (q_pop)
    );

    assign flit_kind = kind_e;
    assign flit_dir  = dir_e;
endmodule

// File: rtl/inj_checker.sv
module inj_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              pkt_stop,
    input logic              vc_pending,
    input logic              router_stop,
    input logic              flit_valid,
    input logic [1:0]        flit_kind,
    input logic [ADDR_W-1:0] flit_dest
);
    logic              in_copy;
    logic [ADDR_W-1:0] copy_dest;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_copy   <= 1'b0;
            copy_dest <= '0;
        end else if (flit_valid) begin
            if (flit_kind == 2'd0) begin
                in_copy   <= 1'b1;
                copy_dest <= flit_dest;
            end else if (flit_kind == 2'd2) begin
                in_copy <= 1'b0;
            end
        end
    end

    // R6
    stall_blocks_flit_chk: assert property (@(posedge clk) disable iff (rst)
        router_stop |-> !flit_valid);

    // R3
    flit_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        flit_valid |-> vc_pending);

    // R2
    empty_not_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        !vc_pending |-> !pkt_stop);

    // R7
    kind_inside_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (flit_valid && in_copy) |-> (flit_kind == 2'd1 || flit_kind == 2'd2));

    // R7
    kind_opens_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (flit_valid && !in_copy) |-> (flit_kind == 2'd0 || flit_kind == 2'd3));

    // R5
    dest_held_in_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (flit_valid && in_copy) |-> (flit_dest == copy_dest));
endmodule

bind pkt_flit_injector inj_checker #(.ADDR_W(ADDR_W)) u_inj_checker (
    .clk         (clk),
    .rst         (rst),
    .pkt_stop    (pkt_stop),
    .vc_pending  (vc_pending),
    .router_stop (router_stop),
    .flit_valid  (flit_valid),
    .flit_kind   (flit_kind),
    .flit_dest   (flit_dest)
);

// File: tb/pkt_flit_injector_bench.sv
`timescale 1ns/1ps
module pkt_flit_injector_bench;
    localparam int ND    = 4;
    localparam int NF    = 4;
    localparam int CW    = 16;
    localparam int AW    = 4;
    localparam int QD    = 4;
    localparam int HX    = 1;
    localparam int HY    = 2;
    localparam int ND_OH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    // Main instance, list mode
    logic           pkt_valid = 0, pkt_has_data = 0, router_stop = 0;
    logic [63:0]    pkt_body = '0;
    logic [15:0]    pkt_dest = '0;
    logic [3:0]     pkt_dest_mask = '0;
    logic           pkt_stop, vc_pending, flit_valid;
    logic [1:0]     flit_kind;
    logic [15:0]    flit_payload;
    logic [3:0]     flit_dest;
    logic [2:0]     flit_dir;

    pkt_flit_injector u_pkt_flit_injector (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_body(pkt_body),
        .pkt_has_data(pkt_has_data), .pkt_dest(pkt_dest), .pkt_dest_mask(pkt_dest_mask),
        .pkt_stop(pkt_stop), .vc_pending(vc_pending), .router_stop(router_stop),
        .flit_valid(flit_valid), .flit_kind(flit_kind), .flit_payload(flit_payload),
        .flit_dest(flit_dest), .flit_dir(flit_dir));

    // Second instance, one-hot destination mode
    logic           o_valid = 0;
    logic [63:0]    o_body = '0;
    logic [63:0]    o_dest = '0;
    logic [15:0]    o_mask = '0;
    logic           o_stop, o_pending, o_fvalid;
    logic [1:0]     o_kind;
    logic [15:0]    o_pay;
    logic [3:0]     o_fdest;
    logic [2:0]     o_dir;

    pkt_flit_injector #(.NUM_DEST(ND_OH), .ONEHOT_DEST(1)) u_pkt_flit_injector_onehot (
        .clk(clk), .rst(rst), .pkt_valid(o_valid), .pkt_body(o_body),
        .pkt_has_data(1'b0), .pkt_dest(o_dest), .pkt_dest_mask(o_mask),
        .pkt_stop(o_stop), .vc_pending(o_pending), .router_stop(1'b0),
        .flit_valid(o_fvalid), .flit_kind(o_kind), .flit_payload(o_pay),
        .flit_dest(o_fdest), .flit_dir(o_dir));

    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] pay;
        logic [3:0]  dest;
        logic [2:0]  dir;
        logic        ends_pkt;
    } exp_t;

    exp_t exp_q[$];
    int   rr_last = ND - 1;
    int   outstanding = 0;
    int   n_chk = 0, n_fail = 0;
    bit   mon_on = 0, bp_on = 0, done = 0;
    int   cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [2:0] exp_dir(input int x, input int y);
        if (x > HX)      return 3'd1;
        else if (x < HX) return 3'd2;
        else if (y > HY) return 3'd3;
        else if (y < HY) return 3'd4;
        else             return 3'd0;
    endfunction

    // Reference model: expand one packet into its flit stream
    task automatic push_exp(input logic [63:0] body, input logic hd,
                            input logic [15:0] dst, input logic [3:0] msk);
        logic [3:0] rem;
        int n;
        exp_t e;
        rem = msk;
        n = hd ? NF : 1;
        while (rem != 0) begin
            int idx;
            idx = -1;
            for (int o = 1; o <= ND; o++)
                if (idx < 0 && rem[(rr_last + o) % ND]) idx = (rr_last + o) % ND;
            rr_last = idx;
            rem[idx] = 1'b0;
            for (int f = 0; f < n; f++) begin
                e.kind = (n == 1) ? 2'd3 : (f == 0) ? 2'd0 : (f == n - 1) ? 2'd2 : 2'd1;
                e.pay  = body[f*CW +: CW];
                e.dest = dst[idx*AW +: AW];
                e.dir  = exp_dir(int'(e.dest[1:0]), int'(e.dest[3:2]));
                e.ends_pkt = (rem == 0) && (f == n - 1);
                exp_q.push_back(e);
            end
        end
    endtask

    // Monitor, away from the active edge
    always @(negedge clk) begin
        if (mon_on && !rst && !done) begin
            chk(vc_pending == (outstanding > 0), "R3", "vc_pending", vc_pending, outstanding > 0);
            chk(pkt_stop == (outstanding >= QD - 1), "R2", "pkt_stop", pkt_stop, outstanding >= QD - 1);
            if (router_stop) chk(!flit_valid, "R6", "flit while stopped", flit_valid, 0);
            if (flit_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R4", "unexpected flit", flit_dest, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(flit_kind == e.kind, "R7", "kind", flit_kind, e.kind);
                    chk(flit_payload == e.pay, "R7 R8", "payload", flit_payload, e.pay);
                    chk(flit_dest == e.dest, "R4 R5", "dest", flit_dest, e.dest);
                    chk(flit_dir == e.dir, "R10", "dir", flit_dir, e.dir);
                    if (e.ends_pkt) outstanding--;
                end
            end
        end
    end

    // Random back-pressure
    always @(posedge clk) begin
        #1;
        if (bp_on) router_stop = ($urandom % 4 == 0);
    end

    task automatic send_pkt(input logic [63:0] body, input logic hd,
                            input logic [15:0] dst, input logic [3:0] msk);
        @(posedge clk); #1;
        while (pkt_stop) begin @(posedge clk); #1; end
        pkt_body = body; pkt_has_data = hd; pkt_dest = dst; pkt_dest_mask = msk;
        pkt_valid = 1'b1;
        push_exp(body, hd, dst, msk);
        @(posedge clk); #1;
        pkt_valid = 1'b0;
        outstanding++;
    endtask

    task automatic drain();
        while (outstanding != 0 || exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_test();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL R9 watchdog: actual=%0d expected=%0d outstanding", outstanding, 0);
            finish_test();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R11: idle after reset
        chk(!flit_valid, "R11", "flit_valid", flit_valid, 0);
        chk(!vc_pending, "R11", "vc_pending", vc_pending, 0);
        chk(!pkt_stop, "R11", "pkt_stop", pkt_stop, 0);
        chk(!o_fvalid && !o_pending, "R11", "onehot idle", o_fvalid, 0);
        mon_on = 1;

        // Full multicast data packet, all four destinations (R4 R7)
        send_pkt(64'h4444_3333_2222_1111, 1'b1, 16'h9A65, 4'b1111);
        drain();
        // Data-less packet to two destinations (R8)
        send_pkt(64'hDEAD_BEEF_CAFE_F00D, 1'b0, 16'h0F30, 4'b1010);
        drain();
        // Back-to-back packets (R9, R1 order)
        send_pkt(64'h0123_4567_89AB_CDEF, 1'b1, 16'h5555, 4'b0100);
        send_pkt(64'h1111_2222_3333_4444, 1'b0, 16'hA0A0, 4'b0011);
        send_pkt(64'h7777_8888_9999_AAAA, 1'b1, 16'hC3C3, 4'b1001);
        drain();

        // Stall with a packet pending (R6)
        router_stop = 1'b1;
        send_pkt(64'h0F0F_F0F0_A5A5_5A5A, 1'b1, 16'h1234, 4'b0110);
        repeat (4) @(negedge clk);
        chk(!flit_valid && vc_pending, "R6", "held while stopped", flit_valid, 0);
        @(posedge clk); #1 router_stop = 1'b0;
        drain();

        // All-zero mask: queued for one cycle, no flit (R9)
        @(posedge clk); #1;
        pkt_body = 64'h1; pkt_has_data = 1'b1; pkt_dest = 16'hFFFF; pkt_dest_mask = 4'b0000;
        pkt_valid = 1'b1;
        @(posedge clk); #1;
        pkt_valid = 1'b0;
        outstanding++;
        @(negedge clk);
        chk(vc_pending, "R9", "zero-mask queued", vc_pending, 1);
        #1 outstanding--;
        @(negedge clk);
        chk(!vc_pending && !flit_valid, "R9", "zero-mask removed", vc_pending, 0);

        // Fill the queue under full stall to see pkt_stop (R2 R1)
        router_stop = 1'b1;
        for (int k = 0; k < QD - 1; k++)
            send_pkt({$urandom, $urandom}, 1'b1, 16'($urandom), 4'(($urandom % 15) + 1));
        @(negedge clk);
        chk(pkt_stop, "R2", "pkt_stop at threshold", pkt_stop, 1);
        @(posedge clk); #1 router_stop = 1'b0;
        drain();

        // Random phase with random stalls
        bp_on = 1;
        for (int k = 0; k < 300; k++) begin
            send_pkt({$urandom, $urandom}, 1'($urandom % 2), 16'($urandom),
                     4'(($urandom % 15) + 1));
            repeat ($urandom % 3) @(posedge clk);
        end
        bp_on = 0;
        @(posedge clk); #1 router_stop = 1'b0;
        drain();

        // One-hot mode: mask bits 5 and 9 give tiles (1,1) and (1,2) (R5)
        @(posedge clk); #1;
        o_body = 64'h0000_0000_0000_BEEF; o_mask = 16'h0220; o_valid = 1'b1;
        @(posedge clk); #1;
        o_valid = 1'b0;
        @(negedge clk);
        chk(o_fvalid && o_kind == 2'd3, "R5", "onehot first kind", o_kind, 3);
        chk(o_fdest == 4'd5, "R5", "onehot first dest", o_fdest, 5);
        chk(o_dir == exp_dir(1, 1), "R10", "onehot first dir", o_dir, exp_dir(1, 1));
        chk(o_pay == 16'hBEEF, "R8", "onehot payload", o_pay, 16'hBEEF);
        @(negedge clk);
        chk(o_fvalid && o_fdest == 4'd9, "R5", "onehot second dest", o_fdest, 9);
        chk(o_dir == exp_dir(1, 2), "R10", "onehot second dir", o_dir, exp_dir(1, 2));
        @(negedge clk);
        chk(!o_fvalid && !o_pending, "R9", "onehot done", o_pending, 0);

        finish_test();
    end
endmodule